// File: doc/BRIEF.md
# DMA Request Line to Channel Mapper

This block sits between a set of peripheral DMA request lines and the channels of a DMA engine. Each request line owns a small mapping register that software programs with a valid flag and a target channel number. While the flag is set, the line's request is routed to the request input of its chosen channel. Several lines may share one channel; their requests are ORed together.

Routed requests are held in a register, one per channel. The block combines them with a per-channel ready vector and issues a single registered one-hot grant each cycle. Priority is fixed by the channel index. Bits 3:2 of the index give one of four levels, and level 0 is the most urgent. Within a level, the lowest index wins. A simple register port writes and reads the mapping registers, and it also reads back a pending bit for each channel.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every mapping register reads 0, all channel requests and grants are 0, and the read data output is 0.
- R2: A mapping register stores write data bit 7 as the valid flag and bits 4:0 as the channel number; it reads back as {valid, 2'b00, channel}, with bits 6:5 always 0.
- R3: The mapping register of line L (L < 64) sits at byte address 0x100 + 4*L, and that of line L (L >= 64) at 0x1100 + 4*(L-64); the two windows are distinct.
- R4: When a line is mapped with valid set and its request input is high, the selected channel's request output is high on the cycle after the input is sampled.
- R5: A line whose valid flag is clear never raises any channel request; writing 0 to its mapping register disconnects it.
- R6: A channel's request output is the OR of the requests of every valid line mapped to it.
- R7: The grant output is one-hot or zero, names only a channel that had both its request and its ready input high on the previous cycle, and is non-zero whenever such a channel existed.
- R8: The priority level of channel c is c[3:2], and a lower level always wins (channel 16 beats channel 4).
- R9: Among candidates of the same level, the lowest channel index wins (channel 5 beats channel 20).
- R10: A read at byte address 0x000 + 4*c returns the channel c request output in bit 0 and zeros elsewhere.
- R11: Writes outside the two mapping windows, or to a line number not implemented, change no mapping register.
- R12: The read data output changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 13 | Byte address of the register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, registered |
| line_req | input | NUM_LINES (72) | Peripheral request lines |
| chan_ready | input | NUM_CHANS (32) | Channel able to accept a grant |
| chan_req | output | NUM_CHANS (32) | Routed request per channel |
| chan_gnt | output | NUM_CHANS (32) | One-hot grant |

## Verification
A wrong mapping entry shows up at the ports one cycle after the affected line is raised: a request appears on the wrong channel or is missing. It is also visible on the read data one cycle after that entry is read. A wrong arbiter choice appears on the grant vector one cycle after the request vector settles, so priority faults appear two cycles after the line input changes. Address decode faults show as one window aliasing the other, which is exposed by writing a line in one window and reading its twin in the other.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;
  localparam int ADDR_W      = 13;
  localparam int DATA_W      = 8;
  localparam int FIELD_CH_W  = 5;
  localparam int VLD_BIT     = 7;
  localparam int LINE_IDX_W  = 7;
  localparam int NUM_LEVELS  = 4;
  localparam int MAX_CHANS   = 1 << FIELD_CH_W;
  localparam int MAX_LINES   = 1 << LINE_IDX_W;

  localparam logic [4:0] WIN_STATUS = 5'h00;
  localparam logic [4:0] WIN_MAP_LO = 5'h01;
  localparam logic [4:0] WIN_MAP_HI = 5'h11;

  typedef struct packed {
    logic                  vld;
    logic [FIELD_CH_W-1:0] ch;
  } map_entry_t;
endpackage

// File: rtl/reqmap_regs.sv
module reqmap_regs
  import reqmap_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHANS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic                        cfg_rd,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  input  logic [NUM_CHANS-1:0]        chan_pend,
  output logic [DATA_W-1:0]           cfg_rdata,
  output map_entry_t [NUM_LINES-1:0]  map_o
);
  localparam int CHS_W = $clog2(NUM_CHANS);

  map_entry_t [NUM_LINES-1:0] map_q, map_d;
  logic [DATA_W-1:0]          rd_q, rd_d;
  logic [4:0]                 win;
  logic [LINE_IDX_W-1:0]      line_idx;
  logic [FIELD_CH_W-1:0]      stat_ch;
  logic                       is_map, is_stat, map_we;

  // address decode: map windows select a line, the status window a channel
  always_comb begin
    win      = cfg_addr[12:8];
    line_idx = {win == WIN_MAP_HI, cfg_addr[7:2]};
    stat_ch  = cfg_addr[6:2];
    is_map   = ((win == WIN_MAP_LO) || (win == WIN_MAP_HI)) &&
               (int'(line_idx) < NUM_LINES);
    is_stat  = (win == WIN_STATUS) && !cfg_addr[7] &&
               (int'(stat_ch) < NUM_CHANS);
    map_we   = cfg_wr && is_map;
  end

  // next-state of the mapping bank
  always_comb begin
    map_d = map_q;
    if (map_we) begin
      map_d[line_idx].vld = cfg_wdata[VLD_BIT];
      map_d[line_idx].ch  = cfg_wdata[FIELD_CH_W-1:0];
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (is_map) begin
      rd_d[VLD_BIT]          = map_q[line_idx].vld;
      rd_d[FIELD_CH_W-1:0]   = map_q[line_idx].ch;
    end else if (is_stat) begin
      rd_d[0] = chan_pend[stat_ch[CHS_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      rd_q  <= '0;
    end else begin
      if (map_we) map_q <= map_d;
      if (cfg_rd) rd_q  <= rd_d;
    end
  end

  assign map_o     = map_q;
  assign cfg_rdata = rd_q;
endmodule

// File: rtl/reqmap_router.sv
module reqmap_router
  import reqmap_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHANS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  map_entry_t [NUM_LINES-1:0]  map_i,
  input  logic [NUM_LINES-1:0]        line_req,
  output logic [NUM_CHANS-1:0]        chan_req
);
  localparam int CHS_W = $clog2(NUM_CHANS);

  logic [NUM_CHANS-1:0] req_d, req_q;

  // each valid, active line sets the bit of the channel it names
  always_comb begin
    req_d = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (map_i[l].vld && line_req[l] && (int'(map_i[l].ch) < NUM_CHANS))
        req_d[map_i[l].ch[CHS_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign chan_req = req_q;
endmodule

// File: rtl/reqmap_arbiter.sv
module reqmap_arbiter
  import reqmap_pkg::*;
#(
  parameter int NUM_CHANS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CHANS-1:0] cand,
  output logic [NUM_CHANS-1:0] gnt
);
  function automatic logic [NUM_CHANS-1:0] level_mask(int lv);
    logic [NUM_CHANS-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CHANS; c++)
      m[c] = (((c >> 2) & 3) == lv);
    return m;
  endfunction

  logic [NUM_CHANS-1:0] lvl_cand [NUM_LEVELS];
  logic [NUM_CHANS-1:0] sel, gnt_d, gnt_q;
  logic                 found;

  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    localparam logic [NUM_CHANS-1:0] LVL_MASK = level_mask(lv);
    assign lvl_cand[lv] = cand & LVL_MASK;
  end

  // pick the most urgent non-empty level, then its lowest set bit
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int lv = 0; lv < NUM_LEVELS; lv++) begin
      if (!found && (|lvl_cand[lv])) begin
        sel   = lvl_cand[lv];
        found = 1'b1;
      end
    end
    gnt_d = sel & (~sel + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import reqmap_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHANS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [12:0]          cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [NUM_LINES-1:0] line_req,
  input  logic [NUM_CHANS-1:0] chan_ready,
  output logic [NUM_CHANS-1:0] chan_req,
  output logic [NUM_CHANS-1:0] chan_gnt
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  map_entry_t [NUM_LINES-1:0] map_w;

  reqmap_regs #(.NUM_LINES(NUM_LINES), .NUM_CHANS(NUM_CHANS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .chan_pend (chan_req),
    .cfg_rdata (cfg_rdata),
    .map_o     (map_w)
  );

  reqmap_router #(.NUM_LINES(NUM_LINES), .NUM_CHANS(NUM_CHANS)) u_router (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .map_i    (map_w),
    .line_req (line_req),
    .chan_req (chan_req)
  );

  reqmap_arbiter #(.NUM_CHANS(NUM_CHANS)) u_arb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .cand  (chan_req & chan_ready),
    .gnt   (chan_gnt)
  );
endmodule

// File: rtl/reqmap_checker.sv
module reqmap_checker #(
  parameter int NUM_LINES = 72,
  parameter int NUM_CHANS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_rd,
  input logic [7:0]           cfg_rdata,
  input logic [NUM_LINES-1:0] line_req,
  input logic [NUM_CHANS-1:0] chan_ready,
  input logic [NUM_CHANS-1:0] chan_req,
  input logic [NUM_CHANS-1:0] chan_gnt
);
  function automatic logic [NUM_CHANS-1:0] top_level();
    logic [NUM_CHANS-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CHANS; c++) m[c] = (((c >> 2) & 3) == 0);
    return m;
  endfunction
  localparam logic [NUM_CHANS-1:0] L0 = top_level();

  assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));

  assert_gnt_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chan_gnt & ~$past(chan_req & chan_ready)) == '0));

  assert_gnt_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_req & chan_ready)) |=> (|chan_gnt));

  assert_level0_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_req & chan_ready & L0)) |=> (|(chan_gnt & L0)));

  assert_req_from_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_req) |-> $past(|line_req));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));
endmodule

bind dma_req_mapper reqmap_checker #(.NUM_LINES(NUM_LINES), .NUM_CHANS(NUM_CHANS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rd     (cfg_rd),
  .cfg_rdata  (cfg_rdata),
  .line_req   (line_req),
  .chan_ready (chan_ready),
  .chan_req   (chan_req),
  .chan_gnt   (chan_gnt)
);

// File: tb/dma_req_mapper_bench.sv
module dma_req_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 72;
  localparam int NC = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr, cfg_rd;
  logic [12:0]   cfg_addr;
  logic [7:0]    cfg_wdata, cfg_rdata;
  logic [NL-1:0] line_req;
  logic [NC-1:0] chan_ready, chan_req, chan_gnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_mapper #(.NUM_LINES(NL), .NUM_CHANS(NC)) u_dma_req_mapper (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .line_req(line_req), .chan_ready(chan_ready),
    .chan_req(chan_req), .chan_gnt(chan_gnt)
  );

  typedef struct {
    logic [NC-1:0] req;
    logic [NC-1:0] gnt;
    logic [7:0]    rd;
    bit            chk_bus;
    bit            chk_rd;
    string         tag;
  } item_t;

  item_t sbq[$];
  item_t mon_it;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // independent model of the mapping bank
  logic          mv [NL];
  logic [4:0]    mc [NL];

  function automatic logic [NC-1:0] model_req();
    logic [NC-1:0] r = '0;
    for (int l = 0; l < NL; l++)
      if (mv[l] && line_req[l] && (int'(mc[l]) < NC)) r[mc[l]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NC-1:0] model_gnt(logic [NC-1:0] cand);
    logic [NC-1:0] g = '0;
    for (int lv = 0; lv < 4; lv++)
      for (int c = 0; c < NC; c++)
        if ((((c / 4) % 4) == lv) && cand[c] && (g == '0)) g[c] = 1'b1;
    return g;
  endfunction

  // monitor: pops one expected item at the falling edge after it is pushed
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      mon_it = sbq.pop_front();
      if (mon_it.chk_bus) begin
        n_chk++;
        if (chan_req !== mon_it.req || chan_gnt !== mon_it.gnt) begin
          n_bad++;
          $display("FAIL %s req=%h gnt=%h expected req=%h gnt=%h",
                   mon_it.tag, chan_req, chan_gnt, mon_it.req, mon_it.gnt);
        end
      end
      if (mon_it.chk_rd) begin
        n_chk++;
        if (cfg_rdata !== mon_it.rd) begin
          n_bad++;
          $display("FAIL %s rdata=%h expected %h", mon_it.tag, cfg_rdata, mon_it.rd);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    int idx;
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    if (a[12:8] == 5'h01 || a[12:8] == 5'h11) begin
      idx = ((a[12:8] == 5'h11) ? 64 : 0) + int'(a[7:2]);
      if (idx < NL) begin mv[idx] = d[7]; mc[idx] = d[4:0]; end
    end
  endtask

  task automatic rd_exp(logic [12:0] a, logic [7:0] e, string tag);
    item_t it;
    cfg_addr = a; cfg_rd = 1'b1;
    tick(1);
    cfg_rd = 1'b0;
    it.req = '0; it.gnt = '0; it.rd = e; it.chk_bus = 0; it.chk_rd = 1; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic hold_exp(logic [7:0] e, string tag);
    item_t it;
    tick(1);
    it.req = '0; it.gnt = '0; it.rd = e; it.chk_bus = 0; it.chk_rd = 1; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic settle_exp(string tag);
    item_t it;
    tick(2);
    it.req = model_req();
    it.gnt = model_gnt(it.req & chan_ready);
    it.rd = '0; it.chk_bus = 1; it.chk_rd = 0; it.tag = tag;
    sbq.push_back(it);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin mv[l] = 1'b0; mc[l] = '0; end
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_addr = '0; cfg_wdata = '0;
    line_req = '0; chan_ready = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R1: reset state
    settle_exp("R1 outputs after reset");
    rd_exp(13'h0100, 8'h00, "R1 line 0 map after reset");
    rd_exp(13'h1100, 8'h00, "R1 line 64 map after reset");

    // R2: field layout, bits 6:5 dropped
    wr(13'h0100, 8'hFF);
    rd_exp(13'h0100, 8'h9F, "R2 readback valid+ch31");
    // R3: second window is a different register
    wr(13'h1100, 8'h85);
    rd_exp(13'h1100, 8'h85, "R3 line 64 readback");
    rd_exp(13'h0100, 8'h9F, "R3 line 0 untouched by high window");
    // R12: read data holds without a strobe
    hold_exp(8'h9F, "R12 rdata hold");
    hold_exp(8'h9F, "R12 rdata hold again");

    // R4: line 64 -> channel 5, not ready yet
    line_req[64] = 1'b1;
    settle_exp("R4 line 64 routes to ch5");
    // R10: status read of channel 5 and 6
    rd_exp(13'h0014, 8'h01, "R10 ch5 pending");
    rd_exp(13'h0018, 8'h00, "R10 ch6 idle");
    // R7: ready -> grant
    chan_ready = '1;
    settle_exp("R7 ch5 granted");

    // R8: ch16 (level 0) beats ch4 and ch5 (level 1)
    wr(13'h0104, 8'h90);
    wr(13'h0108, 8'h84);
    line_req[1] = 1'b1; line_req[2] = 1'b1;
    settle_exp("R8 ch16 wins over ch4/ch5");
    // R7: winner not ready -> next candidate
    chan_ready[16] = 1'b0;
    settle_exp("R7 ready mask skips ch16");
    chan_ready = '1;

    // R9: same level, lowest index
    line_req[1] = 1'b0;
    settle_exp("R9 ch4 beats ch5");
    wr(13'h010C, 8'h94);
    line_req[2] = 1'b0; line_req[3] = 1'b1;
    settle_exp("R9 ch5 beats ch20");

    // R6: two lines onto ch5
    wr(13'h0110, 8'h85);
    line_req[3] = 1'b0; line_req[64] = 1'b0; line_req[4] = 1'b1;
    settle_exp("R6 line 4 alone drives ch5");
    line_req[64] = 1'b1;
    settle_exp("R6 both lines on ch5");

    // R5: clear valid / disconnect
    wr(13'h0110, 8'h05);
    line_req[64] = 1'b0;
    settle_exp("R5 invalid line 4 raises nothing");
    wr(13'h1100, 8'h00);
    line_req[64] = 1'b1;
    settle_exp("R5 zeroed line 64 disconnected");
    rd_exp(13'h0110, 8'h05, "R5 invalid entry readback");

    // R11: writes outside windows and past the last line
    wr(13'h0200, 8'h83);
    wr(13'h1190, 8'h83);
    rd_exp(13'h0100, 8'h9F, "R11 line 0 unchanged");
    rd_exp(13'h1190, 8'h00, "R11 unimplemented line reads 0");
    line_req = '0; line_req[0] = 1'b1;
    settle_exp("R11 line 0 still on ch31");

    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule